// File: doc/BRIEF.md
# Slow-Clock Interval and Real-Time Timer

This block is a system timer driven by a 32768 Hz slow clock. The slow clock reaches the block as a one-cycle strobe, `slow_tick`, in the fast bus clock domain, so all logic runs on `clk`. The block has two timing parts.

- An interval timer counts slow-clock cycles down from a programmable reload value and flags each expiry.
- A real-time counter advances once every N slow-clock cycles, where N is the prescaler setting.

Software uses a small register bus with a write strobe and a read strobe. It reads the event flags, which clear when read, and sets or clears interrupt enables through separate write-one registers. The single active-high `irq` line is raised while any flagged event is also enabled.

Interval timer state machine:
- States: `IT_STOP` (idle) and `IT_RUN` (counting).
- Transition START (`IT_STOP` to `IT_RUN`): a write of a nonzero reload value.
- Transition HALT (`IT_RUN` to `IT_STOP`): a write of zero.
- Transition RELOAD (`IT_RUN` to `IT_RUN`): either a nonzero write, which restarts the count, or an expiry, which reloads the count.

Register map (byte offsets; `rdata` is registered and valid in the cycle after `rd_en`):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | reads 0 | control, not used |
| 0x04 | read/write | interval reload value |
| 0x08 | reads 0 | watchdog mode, not used |
| 0x0C | read/write | prescaler |
| 0x10 | read, clears on read | status |
| 0x14 | write-one-to-set | interrupt enable |
| 0x18 | write-one-to-clear | interrupt enable |
| 0x1C | read | current enables (mask) |
| 0x24 | read | real-time counter |

The status, enable and mask registers share one bit layout: bit 0 is the interval expiry and bit 1 is the real-time counter increment.

Top module: `slowclk_timer`

## Requirements
- R1: After reset the status is 0, the mask is 0, the real-time counter is 0, the prescaler reads 0x8000, `rdata` is 0, `irq` is 0 and the interval timer is stopped.
- R2: After a nonzero reload value N is written to 0x04, status bit 0 sets on the Nth following slow tick, and again every N ticks after that.
- R3: Writing 0 to 0x04 stops the interval timer, and no expiry occurs afterwards. Writing a nonzero value while counting restarts the countdown from that value.
- R4: The real-time counter increments once every P slow ticks, where P is the prescaler value; P of 0 means 65536. Writing the prescaler restarts the division count but leaves the counter value unchanged.
- R5: The real-time counter is RTC_W bits wide (20 by default) and wraps from all ones to 0.
- R6: A read of 0x10 returns the flags as they stood and then clears them. A flag that sets in the same cycle as that read survives it.
- R7: Ones written to 0x14 set the matching enable bits, and ones written to 0x18 clear them. Zero bits change nothing. Offset 0x1C returns the enables.
- R8: `irq` is high exactly while a status bit and its enable bit are both 1, including when the enable is set after the flag.
- R9: Status bit 1 sets on each real-time counter increment.
- R10: Reads of 0x00, 0x08 and unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low asynchronous reset |
| slow_tick | input | 1 | one-cycle strobe per slow-clock period |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 8 | byte offset |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, valid the cycle after rd_en |
| irq | output | 1 | interrupt request, active high |

## Verification
A wrong countdown value or a wrong state in the interval timer shows up as an expiry flag one or more ticks off. The bench sees this at the first status read that follows the expected expiry tick. A wrong prescaler division count gives a counter value that differs at the next read after the affected tick. Enable or status errors appear on `irq` in the cycle after the bus write or tick, because `irq` is combinational over the flag and enable registers.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned NSRC   = 2;
    localparam int unsigned SRC_IT = 0;
    localparam int unsigned SRC_RT = 1;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_WDOG   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PRESC  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IDIS   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IMSK   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RTC    = 8'h24;

    typedef enum logic {
        IT_STOP = 1'b0,
        IT_RUN  = 1'b1
    } it_state_e;
endpackage

// File: rtl/sct_interval.sv
module sct_interval
    import sct_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    it_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, rel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IT_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        expire_o = 1'b0;
        unique case (state_q)
            IT_STOP: if (ld && ld_val != '0) state_d = IT_RUN;
            IT_RUN: begin
                if (ld && ld_val == '0)               state_d  = IT_STOP;
                else if (!ld && tick && cnt_q == ONE) expire_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
            rel_q <= ld_val;
        end else if (state_q == IT_RUN && tick) begin
            cnt_q <= (cnt_q == ONE) ? rel_q : cnt_q - ONE;
        end
    end

    assign reload_o = rel_q;

    // R2: an expiry reloads the countdown from the programmed value
    a_r2_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == rel_q));
    // R3: a stopped timer never expires
    a_r3_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IT_STOP) |-> !expire_o);
    // R3: a zero write always halts the timer
    a_r3_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && ld_val == '0) |=> (state_q == IT_STOP));
endmodule

// File: rtl/sct_rtcount.sv
module sct_rtcount #(
    parameter int unsigned RTC_W   = 20,
    parameter int unsigned PRE_W   = 16,
    parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pre_wr,
    input  logic [PRE_W-1:0] pre_val,
    output logic [PRE_W-1:0] pre_o,
    output logic [RTC_W-1:0] rtc_o,
    output logic             step_o
);
    logic [PRE_W-1:0] pre_q, pcnt_q, lim;
    logic [RTC_W-1:0] rtc_q;

    assign lim    = pre_q - PRE_W'(1);
    assign step_o = tick && !pre_wr && (pcnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= PRE_RST;
            pcnt_q <= '0;
            rtc_q  <= '0;
        end else if (pre_wr) begin
            pre_q  <= pre_val;
            pcnt_q <= '0;
        end else if (tick) begin
            if (pcnt_q == lim) begin
                pcnt_q <= '0;
                rtc_q  <= rtc_q + RTC_W'(1);
            end else begin
                pcnt_q <= pcnt_q + PRE_W'(1);
            end
        end
    end

    assign pre_o = pre_q;
    assign rtc_o = rtc_q;

    // R4: the counter never moves without a slow tick
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rtc_q));
    // R5: an increment steps by one modulo 2^RTC_W
    a_r5_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (rtc_q == $past(rtc_q) + RTC_W'(1)));
    // R4: a prescaler write leaves the counter value alone
    a_r4_prewr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wr |=> $stable(rtc_q));
endmodule

// File: rtl/sct_irqctl.sv
module sct_irqctl #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            stat_rd,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq
);
    logic [NSRC-1:0] stat_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_rd ? '0 : stat_q) | set_i;
            if (en_wr)       en_q <= en_q | wbits;
            else if (dis_wr) en_q <= en_q & ~wbits;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq    = |(stat_q & en_q);

    // R6: a flag raised in the cycle of a status read survives it
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[0] |=> stat_q[0]);
    // R6: a status read with no new event leaves all flags clear
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && set_i == '0) |=> (stat_q == '0));
    // R7: written ones become enabled
    a_r7_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !dis_wr) |=> ((en_q & $past(wbits)) == $past(wbits)));
    // R7: ones written to the disable register clear enables
    a_r7_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && !en_wr) |=> ((en_q & $past(wbits)) == '0));
endmodule

// File: rtl/slowclk_timer.sv
module slowclk_timer
    import sct_pkg::*;
#(
    parameter int unsigned PIT_W = 16,
    parameter int unsigned RTC_W = 20,
    parameter int unsigned PRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic             wr_period, wr_presc, wr_ien, wr_idis, rd_stat;
    logic [PIT_W-1:0] reload;
    logic [PRE_W-1:0] presc;
    logic [RTC_W-1:0] rtc;
    logic             it_expire, rt_step;
    logic [NSRC-1:0]  stat, en, set_vec;
    logic [DATA_W-1:0] rmux;

    assign wr_period = wr_en && addr == OFS_PERIOD;
    assign wr_presc  = wr_en && addr == OFS_PRESC;
    assign wr_ien    = wr_en && addr == OFS_IEN;
    assign wr_idis   = wr_en && addr == OFS_IDIS;
    assign rd_stat   = rd_en && addr == OFS_STAT;

    sct_interval #(.CNT_W(PIT_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slow_tick),
        .ld       (wr_period),
        .ld_val   (wdata[PIT_W-1:0]),
        .reload_o (reload),
        .expire_o (it_expire)
    );

    sct_rtcount #(.RTC_W(RTC_W), .PRE_W(PRE_W)) u_rtcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .pre_wr  (wr_presc),
        .pre_val (wdata[PRE_W-1:0]),
        .pre_o   (presc),
        .rtc_o   (rtc),
        .step_o  (rt_step)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[SRC_IT] = it_expire;
        set_vec[SRC_RT] = rt_step;
    end

    sct_irqctl #(.NSRC(NSRC)) u_irqctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .stat_rd (rd_stat),
        .en_wr   (wr_ien),
        .dis_wr  (wr_idis),
        .wbits   (wdata[NSRC-1:0]),
        .stat_o  (stat),
        .en_o    (en),
        .irq     (irq)
    );

    always_comb begin
        rmux = '0;
        unique case (addr)
            OFS_PERIOD: rmux = DATA_W'(reload);
            OFS_PRESC:  rmux = DATA_W'(presc);
            OFS_STAT:   rmux = DATA_W'(stat);
            OFS_IMSK:   rmux = DATA_W'(en);
            OFS_RTC:    rmux = DATA_W'(rtc);
            default:    rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rmux;
    end

    // R10: reads of the unused control and watchdog offsets return zero
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == OFS_CTRL || addr == OFS_WDOG)) |=> (rdata == '0));
    // R8: irq drops in the cycle after a status read that saw no new event
    a_r8_irq_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !slow_tick) |=> !irq);
endmodule

// File: tb/slowclk_timer_tb.sv
module slowclk_timer_tb;
    localparam int unsigned RTW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    slowclk_timer #(.RTC_W(RTW)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each read result against the queued expectation
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata", rdata, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;
        rd(8'h10, 0, "R1 status");
        rd(8'h1C, 0, "R1 mask");
        rd(8'h24, 0, "R1 rtc");
        rd(8'h0C, 32'h8000, "R1 prescaler");
        ticks(3);
        rd(8'h10, 0, "R1 interval stopped");

        wr(8'h0C, 0);
        wr(8'h04, 5);
        ticks(4);
        rd(8'h10, 0, "R2 before expiry");
        ticks(1);
        rd(8'h10, 1, "R2 expiry");
        rd(8'h10, 0, "R6 cleared by read");
        ticks(5);
        rd(8'h10, 1, "R2 repeat");

        wr(8'h14, 1);
        check("R8 no flag", {31'd0, irq}, 0);
        ticks(5);
        check("R8 flag enabled", {31'd0, irq}, 1);
        wr(8'h18, 1);
        check("R8 disabled", {31'd0, irq}, 0);
        rd(8'h1C, 0, "R7 disable");
        wr(8'h14, 1);
        check("R8 late enable", {31'd0, irq}, 1);
        rd(8'h10, 1, "R6 read flag");
        check("R8 after read", {31'd0, irq}, 0);
        wr(8'h14, 0);
        rd(8'h1C, 1, "R7 zero enable");
        wr(8'h18, 0);
        rd(8'h1C, 1, "R7 zero disable");
        wr(8'h14, 2);
        rd(8'h1C, 3, "R7 set bit1");
        wr(8'h18, 2);
        rd(8'h1C, 1, "R7 clear bit1");

        wr(8'h04, 3);
        ticks(2);
        wr(8'h04, 0);
        ticks(10);
        rd(8'h10, 0, "R3 halted");
        wr(8'h04, 3);
        ticks(2);
        rd(8'h10, 0, "R3 partial");
        wr(8'h04, 4);
        ticks(3);
        rd(8'h10, 0, "R3 restart pending");
        ticks(1);
        rd(8'h10, 1, "R3 restart expiry");

        wr(8'h04, 0);
        rd(8'h24, 0, "R4 rtc idle");
        wr(8'h0C, 1);
        ticks(7);
        rd(8'h24, 7, "R4 prescale 1");
        wr(8'h0C, 3);
        ticks(8);
        rd(8'h24, 9, "R4 prescale 3");
        ticks(1);
        rd(8'h24, 10, "R4 third tick");
        check("R8 bit1 masked", {31'd0, irq}, 0);
        rd(8'h10, 2, "R9 increment flag");
        rd(8'h10, 0, "R9 cleared");

        wr(8'h0C, 1);
        ticks(246);
        rd(8'h24, 0, "R5 wrap");
        ticks(3);
        rd(8'h24, 3, "R5 after wrap");

        rd(8'h00, 0, "R10 control");
        rd(8'h08, 0, "R10 watchdog");
        rd(8'h20, 0, "R10 unmapped");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h1C, 1, "R10 mask kept");
        rd(8'h24, 3, "R10 rtc kept");
        rd(8'h04, 0, "R10 reload kept");

        wr(8'h0C, 0);
        rd(8'h10, 2, "R9 pending flag");
        wr(8'h04, 1);
        @(negedge clk);
        rd_en = 1'b1; addr = 8'h10; slow_tick = 1'b1;
        exp_q.push_back(0); tag_q.push_back("R6 coincident read");
        @(negedge clk);
        rd_en = 1'b0; slow_tick = 1'b0;
        check("R6 set wins irq", {31'd0, irq}, 1);
        rd(8'h10, 1, "R6 set wins");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule